// File: doc/BRIEF.md
# Sub-Coefficient Reconfigurable FIR Filter

This block is a run-time programmable FIR filter in which no tap contains a general multiplier. A single shared precomputer forms the odd multiples one, three, five and seven times the current input sample. Each tap holds a coefficient written as four signed digits in radix 16. For every digit the tap picks one of the eight multiples from one to eight: the odd ones come from the precomputer and the even ones are fixed shifts of them. The tap then forces the pick to zero if the digit is marked zero, moves it to the digit's weight and folds it into a running sum through a chain of add/subtract stages that follow the digit signs.

The taps are chained in transposed direct form, so a sample enters every tap in the same cycle and the partial sums travel through the delay registers. A host writes coefficients one tap at a time through a small write port. An upstream source presents one sample per asserted `in_valid` cycle, and the filtered result appears on `out_sample` one clock later with `out_valid`.

Top module: `subcoef_fir`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first accepted sample, `out_valid` is 0 and `out_sample` is 0. Every tap coefficient resets to the value zero, so the first samples after reset produce 0.
- R2: A coefficient is `NSUB` (4) digits of 5 bits each. Digit k occupies bits [5k+4:5k] and carries weight 16^k. Within a digit, bit 4 is the sign (1 = negative), bit 3 is the zero flag, and bits 2:0 hold the magnitude minus one (000 = 1 through 111 = 8).
- R3: For each magnitude 1 to 8 at each digit position, the tap product equals magnitude × 16^k × sample, for both odd and even magnitudes.
- R4: A digit whose zero flag is set contributes nothing, whatever its sign and magnitude bits hold.
- R5: A digit with the sign bit set is subtracted. This includes the lowest digit, which is negated before the others are combined, so all-negative and mixed-sign coefficients give the exact signed value.
- R6: Each accepted sample x(n) produces out_sample = Σ c_k·x(n−k) over the taps, with c_k the decoded coefficients. It is registered on the edge that accepts the sample, `out_valid` is high for exactly that one following cycle, and back-to-back samples are accepted every cycle.
- R7: Cycles with `in_valid` low leave the filter state and `out_sample` unchanged, whatever value `in_sample` carries. The sequence continues from the next accepted sample as if the gap had not occurred.
- R8: A cycle with `cfg_we` high replaces the coefficient of tap `cfg_tap` only. The new value applies to the products formed for every sample accepted after that edge, and all other taps keep their coefficients.
- R9: The 36-bit result is exact at the extremes: a sample of −32768 with every digit of every tap at +8 yields −4·34952·32768 after four such samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe; one sample accepted per high cycle |
| in_sample | input | 16 | Signed input sample |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_tap | input | 2 | Index of the tap whose coefficient is written |
| cfg_coef | input | 20 | Coefficient as four 5-bit signed digits |
| out_valid | output | 1 | High for the cycle after a sample is accepted |
| out_sample | output | 36 | Signed filter output, held between samples |

## Verification
Every 5-bit digit code is defined, so the assertions place no limit on coefficient words. The product bound assumes only that the sample fits 16 bits signed and the digits decode to at most ±8 each. The hold assertion assumes that reset is not pulsed between samples, and the stimulus raises reset only once at the start. The bench drives coefficient writes only while `in_valid` is low, and it changes a tap other than tap 0 only after a flush of zero samples. This keeps the delay-line contents consistent with a plain dot product of the decoded coefficients.

// File: rtl/subcoef_fir_pkg.sv
package subcoef_fir_pkg;

    // One signed radix-16 digit of a coefficient
    localparam int DIGIT_W = 5;

    typedef struct packed {
        logic       neg;   // subtract this digit
        logic       zero;  // digit contributes nothing
        logic [2:0] idx;   // magnitude minus one
    } digit_t;

    localparam logic [DIGIT_W-1:0] DIGIT_ZERO = 5'b01000;

    // Sum of 16^k for k < n, used for magnitude bounds
    function automatic longint unit_weight_sum(input int n, input int shift);
        longint s;
        s = 0;
        for (int k = 0; k < n; k++) begin
            s = s + (longint'(1) << (k * shift));
        end
        return s;
    endfunction

endpackage

// File: rtl/subcoef_precomp.sv
module subcoef_precomp #(
    parameter int DATA_W = 16,
    localparam int MUL_W = DATA_W + 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DATA_W-1:0] x,
    output logic signed [MUL_W-1:0]  m1,
    output logic signed [MUL_W-1:0]  m3,
    output logic signed [MUL_W-1:0]  m5,
    output logic signed [MUL_W-1:0]  m7
);

    logic signed [MUL_W-1:0] x_ext;

    assign x_ext = x;
    assign m1    = x_ext;
    assign m3    = (x_ext <<< 1) + x_ext;
    assign m5    = (x_ext <<< 2) + x_ext;
    assign m7    = (x_ext <<< 3) - x_ext;

    // R3: odd multiples are evenly spaced by twice the input
    a_r3_odd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (m7 - m5) == (m3 - m1));

endmodule

// File: rtl/subcoef_pe.sv
module subcoef_pe
    import subcoef_fir_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ACC_W     = 36,
    parameter int NSUB      = 4,
    parameter int SUB_SHIFT = 4,
    localparam int MUL_W    = DATA_W + 4,
    localparam int COEF_W   = NSUB * DIGIT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [MUL_W-1:0]  m1,
    input  logic signed [MUL_W-1:0]  m3,
    input  logic signed [MUL_W-1:0]  m5,
    input  logic signed [MUL_W-1:0]  m7,
    input  logic [COEF_W-1:0]        coef,
    output logic signed [ACC_W-1:0]  prod
);

    localparam longint MAX_PROD =
        8 * unit_weight_sum(NSUB, SUB_SHIFT) * (longint'(1) << (DATA_W - 1));

    logic signed [MUL_W-1:0] m2, m4, m6, m8;
    logic signed [ACC_W-1:0] shifted [NSUB];
    logic signed [ACC_W-1:0] chain   [NSUB];
    logic [NSUB-1:0]         neg_v;
    logic [NSUB-1:0]         zero_v;

    // even multiples are plain wiring
    assign m2 = m1 <<< 1;
    assign m4 = m1 <<< 2;
    assign m6 = m3 <<< 1;
    assign m8 = m1 <<< 3;

    generate
        for (genvar k = 0; k < NSUB; k++) begin : g_digit
            digit_t                  dig;
            logic signed [MUL_W-1:0] picked;
            logic signed [MUL_W-1:0] gated;
            logic signed [ACC_W-1:0] widened;

            assign dig = digit_t'(coef[k*DIGIT_W +: DIGIT_W]);

            // 8:1 selection among multiples one to eight
            always_comb begin
                unique case (dig.idx)
                    3'd0:    picked = m1;
                    3'd1:    picked = m2;
                    3'd2:    picked = m3;
                    3'd3:    picked = m4;
                    3'd4:    picked = m5;
                    3'd5:    picked = m6;
                    3'd6:    picked = m7;
                    default: picked = m8;
                endcase
            end

            // AND gating realises a zero digit
            assign gated     = picked & {MUL_W{~dig.zero}};
            assign widened   = gated;
            assign shifted[k] = widened <<< (k * SUB_SHIFT);
            assign neg_v[k]  = dig.neg;
            assign zero_v[k] = dig.zero;
        end

        // add/subtract chain steered by digit signs
        assign chain[0] = neg_v[0] ? -shifted[0] : shifted[0];
        for (genvar k = 1; k < NSUB; k++) begin : g_addsub
            assign chain[k] = neg_v[k] ? (chain[k-1] - shifted[k])
                                       : (chain[k-1] + shifted[k]);
        end
    endgenerate

    assign prod = chain[NSUB-1];

    // R4: all digits flagged zero gives a zero product
    a_r4_all_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (&zero_v) |-> (prod == '0));

    // R9: the product never leaves the range the digits allow
    a_r9_prod_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'(prod) <= MAX_PROD) && (longint'(prod) >= -MAX_PROD));

endmodule

// File: rtl/subcoef_fir.sv
module subcoef_fir
    import subcoef_fir_pkg::*;
#(
    parameter int NTAPS     = 4,
    parameter int DATA_W    = 16,
    parameter int ACC_W     = 36,
    parameter int NSUB      = 4,
    parameter int SUB_SHIFT = 4,
    localparam int TAP_W    = (NTAPS > 1) ? $clog2(NTAPS) : 1,
    localparam int COEF_W   = NSUB * DIGIT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic                     cfg_we,
    input  logic [TAP_W-1:0]         cfg_tap,
    input  logic [COEF_W-1:0]        cfg_coef,
    output logic                     out_valid,
    output logic signed [ACC_W-1:0]  out_sample
);

    localparam int MUL_W = DATA_W + 4;
    localparam logic [COEF_W-1:0] COEF_RST = {NSUB{DIGIT_ZERO}};

    logic signed [MUL_W-1:0] m1, m3, m5, m7;
    logic [COEF_W-1:0]       coef_q [NTAPS];
    logic signed [ACC_W-1:0] prod   [NTAPS];
    logic signed [ACC_W-1:0] zq     [NTAPS];

    subcoef_precomp #(
        .DATA_W (DATA_W)
    ) u_precomp (
        .clk   (clk),
        .rst_n (rst_n),
        .x     (in_sample),
        .m1    (m1),
        .m3    (m3),
        .m5    (m5),
        .m7    (m7)
    );

    generate
        for (genvar t = 0; t < NTAPS; t++) begin : g_tap
            // coefficient register for this tap
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    coef_q[t] <= COEF_RST;
                end else if (cfg_we && (cfg_tap == TAP_W'(t))) begin
                    coef_q[t] <= cfg_coef;
                end
            end

            subcoef_pe #(
                .DATA_W    (DATA_W),
                .ACC_W     (ACC_W),
                .NSUB      (NSUB),
                .SUB_SHIFT (SUB_SHIFT)
            ) u_pe (
                .clk   (clk),
                .rst_n (rst_n),
                .m1    (m1),
                .m3    (m3),
                .m5    (m5),
                .m7    (m7),
                .coef  (coef_q[t]),
                .prod  (prod[t])
            );

            // R8: a write lands in the addressed tap only
            a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && (cfg_tap == TAP_W'(t))) |=> (coef_q[t] == $past(cfg_coef)));
            a_r8_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
                !(cfg_we && (cfg_tap == TAP_W'(t))) |=> $stable(coef_q[t]));
        end

        // transposed delay line: stage s holds the partial sum for tap s
        assign zq[NTAPS-1] = '0;
        for (genvar s = 0; s < NTAPS - 1; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    zq[s] <= '0;
                end else if (in_valid) begin
                    zq[s] <= prod[s+1] + zq[s+1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sample <= prod[0] + zq[0];
            end
        end
    end

    // R7: output holds across cycles without a sample
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sample));

endmodule

// File: tb/subcoef_fir_bench.sv
`timescale 1ns/1ps
module subcoef_fir_bench;

    localparam int NTAPS  = 4;
    localparam int DATA_W = 16;
    localparam int ACC_W  = 36;
    localparam int NSUB   = 4;
    localparam int TAP_W  = 2;
    localparam int COEF_W = NSUB * 5;
    localparam logic [4:0] ZD = 5'b01000;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     in_valid = 1'b0;
    logic signed [DATA_W-1:0] in_sample = '0;
    logic                     cfg_we = 1'b0;
    logic [TAP_W-1:0]         cfg_tap = '0;
    logic [COEF_W-1:0]        cfg_coef = '0;
    logic                     out_valid;
    logic signed [ACC_W-1:0]  out_sample;

    int ntests = 0;
    int nfail  = 0;
    longint c_model [NTAPS];
    longint hist    [NTAPS];

    always #2 clk = ~clk;

    subcoef_fir u_subcoef_fir (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .cfg_we     (cfg_we),
        .cfg_tap    (cfg_tap),
        .cfg_coef   (cfg_coef),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    function automatic logic [4:0] dg(input bit neg, input bit zero, input int mag);
        return {neg, zero, 3'(mag - 1)};
    endfunction

    function automatic longint decode(input logic [COEF_W-1:0] c);
        longint s, v;
        s = 0;
        for (int k = 0; k < NSUB; k++) begin
            v = 0;
            if (!c[k*5+3]) v = longint'(c[k*5 +: 3]) + 1;
            if (c[k*5+4]) v = -v;
            s = s + v * (longint'(1) << (4 * k));
        end
        return s;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        ntests++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint model_out();
        longint s;
        s = 0;
        for (int k = 0; k < NTAPS; k++) s = s + c_model[k] * hist[k];
        return s;
    endfunction

    // one sample, left asserted so calls run back to back
    task automatic push(input longint x, input bit do_chk, input string req);
        in_valid  = 1'b1;
        in_sample = DATA_W'(x);
        for (int k = NTAPS - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        @(negedge clk);
        if (do_chk) begin
            chk(req, longint'(out_sample), model_out());
            chk(req, longint'(out_valid), 1);
        end
    endtask

    task automatic idle(input int n);
        in_valid  = 1'b0;
        in_sample = 16'sh5A5A;
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input int tap, input logic [COEF_W-1:0] c);
        in_valid = 1'b0;
        cfg_we   = 1'b1;
        cfg_tap  = TAP_W'(tap);
        cfg_coef = c;
        @(negedge clk);
        cfg_we   = 1'b0;
        c_model[tap] = decode(c);
    endtask

    task automatic flush();
        for (int k = 0; k < NTAPS; k++) push(0, 1'b0, "");
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 out_valid in reset", longint'(out_valid), 0);
        chk("R1 out_sample in reset", longint'(out_sample), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", longint'(out_valid), 0);
        chk("R1 out_sample after reset", longint'(out_sample), 0);
        push(1234, 1'b1, "R1 zero coefficients");
        push(-777, 1'b1, "R1 zero coefficients");
        idle(1);
    endtask

    task automatic t_digits();
        logic [COEF_W-1:0] c;
        for (int k = 0; k < NSUB; k++) begin
            for (int mag = 1; mag <= 8; mag++) begin
                flush();
                c = {NSUB{ZD}};
                c[k*5 +: 5] = dg(1'b0, 1'b0, mag);
                load(0, c);
                push(-1234, 1'b1, "R2 R3 digit magnitude and weight");
                chk("R3 direct product", longint'(out_sample),
                    longint'(mag) * (longint'(1) << (4 * k)) * -1234);
                idle(1);
            end
        end
    endtask

    task automatic t_zero_flag();
        flush();
        load(0, {ZD, ZD, dg(1'b0, 1'b0, 3), dg(1'b1, 1'b1, 8)});
        push(321, 1'b1, "R4 zero flag ignores sign and magnitude");
        chk("R4 zero flag value", longint'(out_sample), 48 * 321);
        idle(1);
        flush();
        load(0, {dg(1'b1, 1'b1, 5), dg(1'b0, 1'b1, 2), dg(1'b1, 1'b1, 7), dg(1'b0, 1'b1, 1)});
        push(-32768, 1'b1, "R4 all digits flagged zero");
        idle(1);
    endtask

    task automatic t_signs();
        flush();
        load(0, {dg(1'b1, 1'b0, 2), dg(1'b1, 1'b0, 3), dg(1'b1, 1'b0, 4), dg(1'b1, 1'b0, 5)});
        push(1000, 1'b1, "R5 all digits negative");
        chk("R5 all negative value", longint'(out_sample), -(2 * 4096 + 3 * 256 + 4 * 16 + 5) * 1000);
        idle(1);
        flush();
        load(0, {dg(1'b0, 1'b0, 1), dg(1'b1, 1'b0, 8), dg(1'b0, 1'b0, 6), dg(1'b1, 1'b0, 7)});
        push(-555, 1'b1, "R5 mixed signs with negated lowest digit");
        idle(1);
    endtask

    task automatic t_stream();
        flush();
        load(0, {dg(0, 0, 1), ZD, dg(1, 0, 3), dg(0, 0, 7)});
        load(1, {ZD, dg(0, 0, 2), dg(0, 0, 8), dg(1, 0, 1)});
        load(2, {dg(1, 0, 4), dg(0, 0, 5), ZD, dg(0, 0, 6)});
        load(3, {ZD, ZD, dg(1, 0, 2), dg(0, 0, 3)});
        push(100, 1'b1, "R6 stream");
        push(-200, 1'b1, "R6 stream");
        push(32767, 1'b1, "R6 stream");
        push(-32768, 1'b1, "R6 stream");
        push(0, 1'b1, "R6 stream");
        push(7, 1'b1, "R6 stream");
        push(-1, 1'b1, "R6 stream");
        push(12345, 1'b1, "R6 stream");
        idle(1);
        chk("R6 out_valid drops after stream", longint'(out_valid), 0);
    endtask

    task automatic t_idle();
        longint held;
        push(4321, 1'b1, "R7 before gap");
        held = longint'(out_sample);
        idle(3);
        chk("R7 output held through gap", longint'(out_sample), held);
        chk("R7 no valid during gap", longint'(out_valid), 0);
        push(-99, 1'b1, "R7 continues after gap");
        push(250, 1'b1, "R7 continues after gap");
        idle(1);
    endtask

    task automatic t_reload();
        push(1111, 1'b1, "R8 before reload");
        push(-2222, 1'b1, "R8 before reload");
        load(0, {ZD, ZD, dg(0, 0, 5), dg(1, 0, 3)});
        push(3333, 1'b1, "R8 tap0 change applies to next sample");
        push(-44, 1'b1, "R8 tap0 change applies to next sample");
        idle(1);
        flush();
        load(2, {ZD, dg(1, 0, 6), ZD, dg(0, 0, 2)});
        // impulse response shows every tap's coefficient
        push(1, 1'b1, "R8 impulse tap0");
        for (int k = 1; k < NTAPS; k++) push(0, 1'b1, "R8 impulse other taps kept");
        idle(1);
    endtask

    task automatic t_extreme();
        logic [COEF_W-1:0] c;
        flush();
        c = {NSUB{dg(1'b0, 1'b0, 8)}};
        for (int k = 0; k < NTAPS; k++) load(k, c);
        for (int k = 0; k < NTAPS; k++) push(-32768, 1'b1, "R9 extreme accumulation");
        chk("R9 full-scale value", longint'(out_sample), -4 * 34952 * 32768);
        idle(1);
    endtask

    initial begin
        for (int k = 0; k < NTAPS; k++) begin
            c_model[k] = 0;
            hist[k]    = 0;
        end
        repeat (3) @(negedge clk);
        t_reset();
        t_digits();
        t_zero_flag();
        t_signs();
        t_stream();
        t_idle();
        t_reload();
        t_extreme();
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        ntests++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule